// File: doc/BRIEF.md
# Serial Receive Status Logic

This block sits behind the bit-level deserializer of a byte-wide serial controller and holds everything software sees on the receive side. When the deserializer hands over a completed character, the block stores it in a receive data register. It keeps three status flags: receive-full, overrun and framing error. It raises a one-cycle receive interrupt pulse and a level-sensitive error interrupt. Both interrupts are gated by a receive interrupt enable bit in the control register.

A guard timer sets the minimum spacing between characters. Each accepted character reloads a down-counter from the `frame_cycles` input. While the count is nonzero, further arrivals are dropped without any trace. The error interrupt is released in one of two ways. Software can read the status register while it shows an error and then write the error field to zero. Software can also write the control register with the interrupt enable cleared.

Register access uses a simple single-cycle read/write port. Three offsets are decoded: 0 is control, 1 is status and 2 is receive data. Read data is combinational from the current state, and read side effects take hold at the clock edge of the read.

Top module: `rx_status_unit`

## Requirements
- R1: After reset the control, status and receive data registers read 0x00, both interrupt outputs are low and the guard timer is idle.
- R2: An arrival strobe while control bit 4 (receive enable) is 0 is ignored: receive data and status are unchanged.
- R3: An accepted arrival at edge t reloads the guard count from `frame_cycles`. Arrival strobes on the next `frame_cycles` edges are dropped, with no data load and no overrun. A strobe on edge t+`frame_cycles`+1 is accepted.
- R4: An accepted arrival while receive-full (status bit 6) is 0 loads `rx_byte` into receive data and sets receive-full. If control bit 6 (receive interrupt enable) is 1, `rx_irq` is high for exactly the one cycle after that edge.
- R5: An accepted arrival while receive-full is 1 leaves receive data unchanged and sets overrun (status bit 5). If control bit 6 is 1, `err_irq` is raised and held.
- R6: Reading offset 2 returns the stored byte and clears receive-full. Writes to offset 2 have no effect.
- R7: A `brk_strobe` sets framing error (status bit 4) and, with control bit 6 set, raises `err_irq`. It does so independently of receive enable and of the guard timer.
- R8: A status write changes only the error field (bits 5:3) and bit 0. Bit 0 takes the written value. Each error bit is cleared where a 0 is written and kept where a 1 is written, so a write never sets an error bit. Bits 7 and 6 are not affected.
- R9: Every status read records the status in a shadow copy, which resets to zero. A status write lowers `err_irq` only when the shadow's error field was nonzero and the resulting error field is zero. Without such a prior read, `err_irq` stays high.
- R10: A control write with bit 6 at 0 lowers `err_irq`. While bit 6 is 0, no arrival or break raises `rx_irq` or `err_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_cycles | input | CNT_W | Guard interval in clock cycles, loaded on each accepted arrival |
| rx_strobe | input | 1 | One-cycle strobe: a character has been deserialized |
| rx_byte | input | 8 | Character accompanying `rx_strobe` |
| brk_strobe | input | 1 | One-cycle strobe: a break condition was detected |
| reg_addr | input | 2 | Register offset (0 control, 1 status, 2 receive data) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| err_irq | output | 1 | Level error interrupt |

## Verification
The bench aims at the edges of the guard window. An off-by-one counter would accept the strobe one edge too early, or drop the first legal one, and the result would show as a wrong overrun bit or a wrong data byte. It checks that an overrun keeps the first byte, since a design that overwrites would return the later character. It checks that a status write cannot set an error bit, and that `err_irq` survives a write-zero that was not preceded by a status read, since a release that skips the shadow check would drop the interrupt too early. Random traffic with changing frame lengths, break strobes and interleaved register accesses is compared cycle by cycle against a bench model.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int ERR_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 2'd2;

  // control bit positions
  localparam int CTRL_RXEN = 4;
  localparam int CTRL_RIE  = 6;

  // status bit positions; error field is bits ERR_LO+2:ERR_LO = {ovr, fer, par}
  localparam int ST_FULL = 6;
  localparam int ERR_LO  = 3;
  localparam int ST_USR  = 0;

  // error bits survive a status write only where a 1 is written
  function automatic logic [ERR_W-1:0] err_after_write(logic [ERR_W-1:0] cur,
                                                       logic [DATA_W-1:0] w);
    return cur & w[ERR_LO +: ERR_W];
  endfunction

  // release condition for the error interrupt
  function automatic logic clear_seq_hit(logic [ERR_W-1:0] seen,
                                         logic [ERR_W-1:0] now);
    return (seen != '0) && (now == '0);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(logic full,
                                                    logic [ERR_W-1:0] err,
                                                    logic usr);
    logic [DATA_W-1:0] s;
    s = '0;
    s[ST_FULL]            = full;
    s[ERR_LO +: ERR_W]    = err;
    s[ST_USR]             = usr;
    return s;
  endfunction
endpackage

// File: rtl/rx_guard_timer.sv
module rx_guard_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] frame_i,
  output logic             accept_o,
  output logic             idle_o
);
  logic [CNT_W-1:0] cnt_q;

  assign idle_o   = (cnt_q == '0);
  assign accept_o = strobe_i & en_i & idle_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (accept_o)     cnt_q <= frame_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  AST_GUARD_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank
  import rx_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              brk_i,
  input  logic              rd_rxd_i,
  input  logic              rd_stat_i,
  input  logic              wr_stat_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  output logic [ERR_W-1:0]  err_o,
  output logic              usr_o,
  output logic [DATA_W-1:0] rxd_o,
  output logic              load_o,
  output logic              ovr_evt_o,
  output logic              clear_hit_o
);
  logic              full_q, usr_q;
  logic [ERR_W-1:0]  err_q, shadow_q, err_wr, err_nxt;
  logic [DATA_W-1:0] rxd_q;

  assign load_o    = acc_i & ~full_q;
  assign ovr_evt_o = acc_i & full_q;

  always_comb begin
    err_wr  = wr_stat_i ? err_after_write(err_q, wdata_i) : err_q;
    err_nxt = err_wr | {ovr_evt_o, brk_i, 1'b0};
  end

  assign clear_hit_o = wr_stat_i & clear_seq_hit(shadow_q, err_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      usr_q    <= 1'b0;
      err_q    <= '0;
      shadow_q <= '0;
      rxd_q    <= '0;
    end else begin
      err_q <= err_nxt;
      if (load_o)        full_q <= 1'b1;
      else if (rd_rxd_i) full_q <= 1'b0;
      if (load_o)        rxd_q  <= byte_i;
      if (wr_stat_i)     usr_q  <= wdata_i[ST_USR];
      if (rd_stat_i)     shadow_q <= err_q;
    end
  end

  assign full_o = full_q;
  assign err_o  = err_q;
  assign usr_o  = usr_q;
  assign rxd_o  = rxd_q;

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt_o |=> ($stable(rxd_q) && err_q[2])); // R5
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (full_q && rxd_q == $past(byte_i))); // R4
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd_i && !load_o) |=> !full_q); // R6
  AST_BREAK_FER: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> err_q[1]); // R7
  AST_WRITE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat_i && !ovr_evt_o && !brk_i) |=> ((err_q & ~$past(err_q)) == '0)); // R8
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rie_i,
  input  logic load_i,
  input  logic err_set_i,
  input  logic err_clr_i,
  output logic rx_pulse_o,
  output logic err_irq_o
);
  logic pulse_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= load_i & rie_i;
      if (err_set_i)      err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign rx_pulse_o = pulse_q;
  assign err_irq_o  = err_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R4
  AST_PULSE_NEEDS_RIE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(rie_i)); // R10
endmodule

// File: rtl/rx_status_unit.sv
module rx_status_unit
  import rx_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  frame_cycles,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              brk_strobe,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rx_irq,
  output logic              err_irq
);
  logic [DATA_W-1:0] ctrl_q;
  logic              rd_ctrl, rd_stat, rd_rxd, wr_ctrl, wr_stat;
  logic              accept, guard_idle;
  logic              full, usr, load_evt, ovr_evt, clear_hit;
  logic [ERR_W-1:0]  err;
  logic [DATA_W-1:0] rxd;
  logic              rie, err_set, err_clr;

  assign rd_ctrl = reg_rd & (reg_addr == OFS_CTRL);
  assign rd_stat = reg_rd & (reg_addr == OFS_STAT);
  assign rd_rxd  = reg_rd & (reg_addr == OFS_RXD);
  assign wr_ctrl = reg_wr & (reg_addr == OFS_CTRL);
  assign wr_stat = reg_wr & (reg_addr == OFS_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata;
  end

  assign rie = ctrl_q[CTRL_RIE];

  rx_guard_timer #(.CNT_W(CNT_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (rx_strobe),
    .en_i     (ctrl_q[CTRL_RXEN]),
    .frame_i  (frame_cycles),
    .accept_o (accept),
    .idle_o   (guard_idle)
  );

  rx_flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (accept),
    .byte_i      (rx_byte),
    .brk_i       (brk_strobe),
    .rd_rxd_i    (rd_rxd),
    .rd_stat_i   (rd_stat),
    .wr_stat_i   (wr_stat),
    .wdata_i     (reg_wdata),
    .full_o      (full),
    .err_o       (err),
    .usr_o       (usr),
    .rxd_o       (rxd),
    .load_o      (load_evt),
    .ovr_evt_o   (ovr_evt),
    .clear_hit_o (clear_hit)
  );

  assign err_set = (ovr_evt | brk_strobe) & rie;
  assign err_clr = (wr_ctrl & ~reg_wdata[CTRL_RIE]) | clear_hit;

  rx_irq_gen u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rie_i      (rie),
    .load_i     (load_evt),
    .err_set_i  (err_set),
    .err_clr_i  (err_clr),
    .rx_pulse_o (rx_irq),
    .err_irq_o  (err_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (rd_ctrl)      reg_rdata = ctrl_q;
    else if (rd_stat) reg_rdata = pack_status(full, err, usr);
    else if (rd_rxd)  reg_rdata = rxd;
  end

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && !ctrl_q[CTRL_RXEN]) |=> $stable(rxd)); // R2
  AST_GUARD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && !guard_idle && !brk_strobe && !wr_stat) |=> $stable(rxd) && $stable(err)); // R3
  AST_CTRL_RELEASES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !reg_wdata[CTRL_RIE] && !err_set) |=> !err_irq); // R10
  AST_ERR_NEEDS_RIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(rie)); // R10
endmodule

// File: tb/test_rx_status_unit.sv
module test_rx_status_unit;
  localparam int CNT_W = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_RXD = 2'd2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] frame_cycles;
  logic             rx_strobe, brk_strobe, reg_rd, reg_wr;
  logic [7:0]       rx_byte, reg_wdata, reg_rdata;
  logic [1:0]       reg_addr;
  logic             rx_irq, err_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_status_unit #(.CNT_W(CNT_W)) i_rx_status_unit (
    .clk(clk), .rst_n(rst_n), .frame_cycles(frame_cycles),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .brk_strobe(brk_strobe),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_irq(rx_irq), .err_irq(err_irq)
  );

  // bench model of the requirements
  logic [7:0]  m_ctrl, m_rxd;
  logic        m_full, m_ovr, m_fer, m_par, m_usr, m_rxirq, m_errirq;
  logic [2:0]  m_shadow;
  int unsigned m_guard;
  logic [7:0]  last_rdata;

  function automatic logic [7:0] exp_status();
    return {1'b0, m_full, m_ovr, m_fer, m_par, 2'b00, m_usr};
  endfunction

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      A_CTRL:  return m_ctrl;
      A_STAT:  return exp_status();
      A_RXD:   return m_rxd;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 0; m_rxd = 0; m_full = 0; m_ovr = 0; m_fer = 0; m_par = 0;
    m_usr = 0; m_rxirq = 0; m_errirq = 0; m_shadow = 0; m_guard = 0;
  endtask

  // one clock cycle of stimulus; called just after a falling edge
  task automatic cyc(bit stb, logic [7:0] b, bit brk, bit rd, bit wr,
                     logic [1:0] a, logic [7:0] w);
    bit acc, ld, ov, hit;
    logic n_ovr, n_fer, n_par;
    rx_strobe = stb; rx_byte = b; brk_strobe = brk;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = w;
    #1;
    if (rd) begin
      last_rdata = reg_rdata;
      check(a == A_STAT ? "R8 status read" : a == A_RXD ? "R6 data read" : "R1 control read",
            reg_rdata, exp_read(a));
    end
    acc = stb && m_ctrl[4] && (m_guard == 0);
    ld  = acc && !m_full;
    ov  = acc && m_full;
    n_ovr = (wr && a == A_STAT) ? (m_ovr & w[5]) : m_ovr;
    n_fer = (wr && a == A_STAT) ? (m_fer & w[4]) : m_fer;
    n_par = (wr && a == A_STAT) ? (m_par & w[3]) : m_par;
    n_ovr = n_ovr | ov;
    n_fer = n_fer | brk;
    hit = wr && a == A_STAT && (m_shadow != 0) && ({n_ovr, n_fer, n_par} == 0);
    @(posedge clk);
    if ((ov || brk) && m_ctrl[6])                 m_errirq = 1;
    else if ((wr && a == A_CTRL && !w[6]) || hit) m_errirq = 0;
    m_rxirq = ld && m_ctrl[6];
    if (rd && a == A_STAT) m_shadow = {m_ovr, m_fer, m_par};
    if (wr && a == A_STAT) m_usr = w[0];
    m_ovr = n_ovr; m_fer = n_fer; m_par = n_par;
    if (ld) begin m_full = 1; m_rxd = b; end
    else if (rd && a == A_RXD) m_full = 0;
    if (acc) m_guard = frame_cycles;
    else if (m_guard != 0) m_guard--;
    if (wr && a == A_CTRL) m_ctrl = w;
    @(negedge clk);
    rx_strobe = 0; brk_strobe = 0; reg_rd = 0; reg_wr = 0;
    check("R4 rx_irq", rx_irq, m_rxirq);
    check("R9 err_irq", err_irq, m_errirq);
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    cyc(0, 0, 0, 1, 0, a, 0);
    check(tag, last_rdata, exp);
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] w);
    cyc(0, 0, 0, 0, 1, a, w);
  endtask
  task automatic strobe(logic [7:0] b);
    cyc(1, b, 0, 0, 0, 0, 0);
  endtask
  task automatic brk();
    cyc(0, 0, 1, 0, 0, 0, 0);
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; frame_cycles = 4;
    rx_strobe = 0; rx_byte = 0; brk_strobe = 0;
    reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 rx_irq after reset", rx_irq, 0);
    check("R1 err_irq after reset", err_irq, 0);
    rd(A_CTRL, 8'h00, "R1 control");
    rd(A_STAT, 8'h00, "R1 status");
    rd(A_RXD,  8'h00, "R1 data");
    // R2 receive disabled
    strobe(8'hA5);
    rd(A_RXD,  8'h00, "R2 data untouched");
    rd(A_STAT, 8'h00, "R2 status untouched");
    wr(A_CTRL, 8'h50);
    // R4 load and pulse
    strobe(8'h3C);
    check("R4 pulse high", rx_irq, 1);
    strobe(8'h77);                    // guard 4 -> dropped
    check("R4 pulse one cycle", rx_irq, 0);
    idle();
    rd(A_STAT, 8'h40, "R3 no overrun inside window");
    strobe(8'h99);                    // last edge of window -> dropped
    strobe(8'h88);                    // first legal edge -> overrun
    check("R5 err_irq on overrun", err_irq, 1);
    rd(A_RXD,  8'h3C, "R5 data kept on overrun");
    rd(A_STAT, 8'h20, "R6 full cleared by data read");
    wr(A_RXD, 8'hFF);
    rd(A_RXD,  8'h3C, "R6 data write ignored");
    wr(A_STAT, 8'h01);
    check("R9 release after read then write zero", err_irq, 0);
    rd(A_STAT, 8'h01, "R8 bit0 written, error cleared");
    brk();
    check("R7 err_irq on break", err_irq, 1);
    wr(A_STAT, 8'h00);
    check("R9 no release without prior read", err_irq, 1);
    rd(A_STAT, 8'h00, "R8 framing cleared by write");
    brk();
    rd(A_STAT, 8'h10, "R7 framing flag set");
    wr(A_CTRL, 8'h10);
    check("R10 control write releases err", err_irq, 0);
    strobe(8'h5A);
    check("R10 no pulse without enable", rx_irq, 0);
    brk();
    check("R10 no err_irq without enable", err_irq, 0);
    rd(A_STAT, 8'h50, "R4 full with framing");
    wr(A_STAT, 8'h38);
    rd(A_STAT, 8'h50, "R8 write of ones sets nothing");
    wr(A_STAT, 8'h80);
    rd(A_STAT, 8'h40, "R8 bits 7:6 unaffected");
    rd(A_RXD,  8'h5A, "R4 data loaded");
    // constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [1:0]  a;
      logic [7:0]  w;
      if (i % 250 == 0) frame_cycles = CNT_W'($urandom % 6);
      r = $urandom % 16;
      a = 2'($urandom % 3);
      w = 8'($urandom);
      if (a == A_CTRL) w[4] = ($urandom % 4) != 0;
      if (r < 6)       strobe(8'($urandom));
      else if (r < 7)  brk();
      else if (r < 11) cyc(0, 0, 0, 1, 0, a, 0);
      else if (r < 14) wr(a, w);
      else if (r < 15) cyc(1, 8'($urandom), 0, 1, 0, A_RXD, 0);
      else             idle();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule